// File: doc/BRIEF.md
# Two-Wire Register Target with Memory Streaming

This block is a target-only two-wire serial bus interface (I2C) that gives a host controller access to a small byte-wide register file and to two write-only byte memories. The host writes one register or a run of consecutive registers, and reads one register as often as it likes. Through either of two port addresses it streams any number of bytes into a memory. A strap input selects one of two 7-bit device addresses, so two identical devices can share one bus.

SCL and SDA are sampled by the system clock through a two-flop synchronizer. START and STOP are detected as SDA edges while SCL is high. SDA is driven only as an open-drain enable: a high `sda_oe` pulls the line low. The interrupt output works the same way. `irq_oe` high pulls the active-low interrupt line low, so several devices can share it as a wired-OR. Event inputs latch into a flag register. An enable register masks which flags reach the line. A status register shows the raw event inputs, and reading the flag register clears it.

The register map is as follows. Address 0x00 is control, with bit 0 requesting a soft reset. Address 0x01 is the interrupt enable and 0x02 holds the interrupt flags. Address 0x03 is the raw status. Addresses 0x04 to 0x07 are general read/write registers. Addresses 0x10 and 0x11 are the ports of memory A and memory B. The rest of the logic reads the memories through their own address inputs.

Top module: `i2c_regslave`

## Requirements
- R1: Only an address byte whose upper seven bits equal the device address is acknowledged (SDA low in the ninth clock). Any other address is not acknowledged, and the data bytes that follow it change nothing.
- R2: The first data byte after the write address sets the register address. A following data byte is stored in that register, and registers 0x00, 0x01 and 0x04 to 0x07 read back what was written.
- R3: In a write of several data bytes to a non-port register address n, the bytes go to n, n+1, n+2 and so on in order.
- R4: A read is a write transaction that sets the register address, followed by a repeated START and the read address (device address with bit 0 set). Every byte of a multi-byte read returns the same register.
- R5: After register address 0x10 (memory A) or 0x11 (memory B), successive data bytes go to locations 0, 1, 2 and onward of that memory. The index restarts at 0 each time a port address is received, and the other memory is left unchanged.
- R6: Data bytes beyond the memory depth (16 by default) are acknowledged but dropped, and no earlier location is overwritten.
- R7: An event input that is high sets its bit in the flag register (0x02). `irq_oe` is high exactly while some flag bit is set whose bit is also set in the enable register (0x01). The status register (0x03) returns the live event inputs.
- R8: When the flag register is fetched for a read, the byte returned holds the flags and those flags are cleared. Events present in that same cycle stay set.
- R9: Writing 1 to bit 0 of register 0x00 gives a `soft_rst` pulse exactly one cycle long, one cycle after the STOP that ends the transaction. There is no pulse before that STOP, and the bit reads back as 0 afterwards.
- R10: Writes to 0x02, 0x03 and unmapped addresses are ignored. Reads of unmapped addresses and of the two memory ports return 0x00.
- R11: After reset `sda_oe`, `irq_oe` and `soft_rst` are low and every register reads 0x00.
- R12: The 7-bit device address is 0x6E when `addr_sel` is low and 0x6F when it is high (write/read address bytes 0xDC/0xDD and 0xDE/0xDF).
- R13: SDA is released on START, on STOP and after the host does not acknowledge a read byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap selecting the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| irq_oe | output | 1 | High pulls the active-low interrupt line low |
| evt_i | input | 8 | Interrupt event inputs, one per flag bit |
| soft_rst | output | 1 | One-cycle soft reset pulse to other blocks |
| mema_raddr | input | MEM_AW | Read index into memory A |
| mema_rdata | output | 8 | Byte at `mema_raddr` |
| memb_raddr | input | MEM_AW | Read index into memory B |
| memb_rdata | output | 8 | Byte at `memb_raddr` |

## Verification
Every result is delayed by the two synchronizer flops and the edge-detect flop. A register or memory write lands about four system cycles after the SCL falling edge that closes the byte. The acknowledge and the transmitted bits appear on `sda_oe` after the same delay following SCL low, and `soft_rst` pulses about five cycles after SDA rises for the STOP. The bench holds every SCL phase for eight system cycles. It samples SDA in the middle of the high phase, reads memories and flags only after a whole quarter period has passed, and waits ten cycles after a STOP before counting soft reset pulses. This way each check falls well after its result is due and before the next stimulus can change it.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam logic [7:0] RA_CTRL   = 8'h00;
    localparam logic [7:0] RA_IRQ_EN = 8'h01;
    localparam logic [7:0] RA_FLAGS  = 8'h02;
    localparam logic [7:0] RA_STATUS = 8'h03;
    localparam logic [7:0] RA_GP0    = 8'h04;
    localparam logic [7:0] RA_MEM_A  = 8'h10;
    localparam logic [7:0] RA_MEM_B  = 8'h11;

    localparam int EVT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    function automatic logic is_mem_port(input logic [7:0] a);
        return (a == RA_MEM_A) || (a == RA_MEM_B);
    endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic  scl_s;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign bus_start = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign bus_stop  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_BASE = 7'h6E,
    parameter int         MEM_DEPTH     = 16,
    localparam int        IDX_W         = $clog2(MEM_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic [7:0]       reg_addr,
    output logic [7:0]       data_byte,
    output logic             wr_en,
    output logic             mem_we,
    output logic             mem_sel,
    output logic [IDX_W-1:0] mem_idx,
    output logic             rd_load
);

    localparam logic [IDX_W-1:0] DEPTH_C = IDX_W'(MEM_DEPTH);

    typedef struct packed {
        bus_state_e       st;
        logic [3:0]       cnt;
        logic [7:0]       sr;
        logic             oe;
        logic             rw;
        logic             first;
        logic             mack;
        logic [7:0]       ra;
        logic [IDX_W-1:0] idx;
    } eng_t;

    eng_t       q, d;
    logic [6:0] own_addr;

    assign own_addr = {DEV_ADDR_BASE[6:1], addr_sel};

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        mem_we  = 1'b0;
        rd_load = 1'b0;
        if (bus_start) begin
            d.st    = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.first = 1'b1;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sr[7:1] == own_addr) begin
                                d.oe = 1'b1;
                                d.rw = q.sr[0];
                                d.st = ST_ADDR_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.st = ST_RX_ACK;
                            if (q.first) begin
                                d.ra    = q.sr;
                                d.first = 1'b0;
                                if (is_mem_port(q.sr)) d.idx = '0;
                            end else if (is_mem_port(q.ra)) begin
                                if (q.idx < DEPTH_C) begin
                                    mem_we = 1'b1;
                                    d.idx  = q.idx + 1'b1;
                                end
                            end else begin
                                wr_en = 1'b1;
                                d.ra  = q.ra + 8'd1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            rd_load = 1'b1;
                            d.sr    = rd_data;
                            d.oe    = ~rd_data[7];
                            d.st    = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_RX;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe = 1'b0;
                            d.st = ST_TX_ACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sr  = {q.sr[6:0], 1'b0};
                            d.oe  = ~q.sr[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            rd_load = 1'b1;
                            d.sr    = rd_data;
                            d.oe    = ~rd_data[7];
                            d.cnt   = '0;
                            d.st    = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign reg_addr  = q.ra;
    assign data_byte = q.sr;
    assign mem_sel   = (q.ra == RA_MEM_B);
    assign mem_idx   = q.idx;

endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs
    import i2c_rs_pkg::*;
#(
    parameter int NUM_GP    = 4,
    parameter int MEM_DEPTH = 16,
    localparam int MEM_AW   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        data_byte,
    input  logic              wr_en,
    input  logic              rd_load,
    input  logic              mem_we,
    input  logic              mem_sel,
    input  logic [MEM_AW-1:0] mem_waddr,
    input  logic              bus_stop,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [MEM_AW-1:0] mema_raddr,
    input  logic [MEM_AW-1:0] memb_raddr,
    output logic [7:0]        rd_data,
    output logic [EVT_W-1:0]  irq_en,
    output logic              irq_oe,
    output logic              soft_rst,
    output logic [7:0]        mema_rdata,
    output logic [7:0]        memb_rdata
);

    typedef struct packed {
        logic [7:0]             ctrl;
        logic [EVT_W-1:0]       en;
        logic [EVT_W-1:0]       flags;
        logic [NUM_GP-1:0][7:0] gp;
        logic                   srst;
    } regs_t;

    regs_t q, d;

    always_comb begin
        rd_data = 8'h00;
        if (reg_addr == RA_CTRL)   rd_data = q.ctrl;
        if (reg_addr == RA_IRQ_EN) rd_data = q.en;
        if (reg_addr == RA_FLAGS)  rd_data = q.flags;
        if (reg_addr == RA_STATUS) rd_data = evt_i;
        for (int i = 0; i < NUM_GP; i++) begin
            if (reg_addr == RA_GP0 + 8'(i)) rd_data = q.gp[i];
        end
    end

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        if (wr_en) begin
            if (reg_addr == RA_CTRL)   d.ctrl = data_byte;
            if (reg_addr == RA_IRQ_EN) d.en   = data_byte;
            for (int i = 0; i < NUM_GP; i++) begin
                if (reg_addr == RA_GP0 + 8'(i)) d.gp[i] = data_byte;
            end
        end
        if (rd_load && reg_addr == RA_FLAGS) d.flags = '0;
        d.flags = d.flags | evt_i;
        if (bus_stop && q.ctrl[0]) begin
            d.srst    = 1'b1;
            d.ctrl[0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [1:0][7:0] mem_rd;

    for (genvar m = 0; m < 2; m++) begin : g_mem
        localparam logic SEL = (m == 1);
        logic [MEM_DEPTH-1:0][7:0] cell_q, cell_d;

        always_comb begin
            cell_d = cell_q;
            if (mem_we && mem_sel == SEL) cell_d[mem_waddr] = data_byte;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign mem_rd[m] = cell_q[(m == 0) ? mema_raddr : memb_raddr];
    end

    assign mema_rdata = mem_rd[0];
    assign memb_rdata = mem_rd[1];
    assign irq_en     = q.en;
    assign irq_oe     = |(q.flags & q.en);
    assign soft_rst   = q.srst;

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_BASE = 7'h6E,
    parameter int         NUM_GP        = 4,
    parameter int         MEM_DEPTH     = 16,
    parameter int         SYNC_STAGES   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         addr_sel,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe,
    output logic                         irq_oe,
    input  logic [7:0]                   evt_i,
    output logic                         soft_rst,
    input  logic [$clog2(MEM_DEPTH)-1:0] mema_raddr,
    output logic [7:0]                   mema_rdata,
    input  logic [$clog2(MEM_DEPTH)-1:0] memb_raddr,
    output logic [7:0]                   memb_rdata
);

    localparam int MEM_AW = $clog2(MEM_DEPTH);
    localparam int IDX_W  = $clog2(MEM_DEPTH + 1);

    logic             sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0]       reg_addr, data_byte, rd_data;
    logic             wr_en, mem_we, mem_sel, rd_load;
    logic [IDX_W-1:0] mem_idx;
    logic [7:0]       irq_en;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_rs_engine #(.DEV_ADDR_BASE(DEV_ADDR_BASE), .MEM_DEPTH(MEM_DEPTH)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .data_byte (data_byte),
        .wr_en     (wr_en),
        .mem_we    (mem_we),
        .mem_sel   (mem_sel),
        .mem_idx   (mem_idx),
        .rd_load   (rd_load)
    );

    i2c_rs_regs #(.NUM_GP(NUM_GP), .MEM_DEPTH(MEM_DEPTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .data_byte  (data_byte),
        .wr_en      (wr_en),
        .rd_load    (rd_load),
        .mem_we     (mem_we),
        .mem_sel    (mem_sel),
        .mem_waddr  (mem_idx[MEM_AW-1:0]),
        .bus_stop   (bus_stop),
        .evt_i      (evt_i),
        .mema_raddr (mema_raddr),
        .memb_raddr (memb_raddr),
        .rd_data    (rd_data),
        .irq_en     (irq_en),
        .irq_oe     (irq_oe),
        .soft_rst   (soft_rst),
        .mema_rdata (mema_rdata),
        .memb_rdata (memb_rdata)
    );

endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker #(
    parameter int MEM_DEPTH = 16,
    parameter int IDX_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             irq_oe,
    input logic             soft_rst,
    input logic             bus_start,
    input logic             bus_stop,
    input logic [7:0]       evt_i,
    input logic [7:0]       irq_en,
    input logic             wr_en,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_idx
);

    // R9: the reset pulse lasts a single cycle
    assert_srst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R9: the reset pulse only follows a stop
    assert_srst_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(bus_stop));

    // R7: an enabled event drives the interrupt line in the next cycle
    assert_irq_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & irq_en)) && !wr_en) |=> irq_oe);

    // R7: with every source masked the line stays released
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 8'h00) |-> !irq_oe);

    // R6: no memory write at or beyond the depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_idx < IDX_W'(MEM_DEPTH)));

    // R13: data line released after a start
    assert_release_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !sda_oe);

    // R13: data line released after a stop
    assert_release_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

endmodule

bind i2c_regslave i2c_rs_checker #(.MEM_DEPTH(MEM_DEPTH), .IDX_W($clog2(MEM_DEPTH + 1))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .irq_oe    (irq_oe),
    .soft_rst  (soft_rst),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .evt_i     (evt_i),
    .irq_en    (irq_en),
    .wr_en     (wr_en),
    .mem_we    (mem_we),
    .mem_idx   (mem_idx)
);

// File: tb/test_i2c_regslave.sv
module test_i2c_regslave;

    localparam int Q     = 8;
    localparam int DEPTH = 16;
    localparam int NGP   = 4;

    localparam logic [7:0] A_CTRL = 8'h00, A_EN = 8'h01, A_FLG = 8'h02, A_STS = 8'h03;
    localparam logic [7:0] A_GP = 8'h04, A_MA = 8'h10, A_MB = 8'h11, A_NONE = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_sel = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] evt = 8'h00;
    logic [3:0] ra_a = '0, ra_b = '0;
    logic       sda_oe, irq_oe, soft_rst;
    logic [7:0] rd_a, rd_b;
    wire        sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int srst_cnt = 0;

    logic [7:0] wbuf [32];
    logic [7:0] rbuf [8];
    logic [7:0] gp_model [NGP];

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n && soft_rst) srst_cnt++;

    i2c_regslave i_i2c_regslave (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .irq_oe(irq_oe), .evt_i(evt), .soft_rst(soft_rst),
        .mema_raddr(ra_a), .mema_rdata(rd_a), .memb_raddr(ra_b), .memb_rdata(rd_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = ~sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq();
            b[i] = sda_line;
            wq(); scl_m = 1'b0;
        end
        wq(); sda_m = ~host_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [6:0] dev_of(input logic sel);
        return {6'b110111, sel};
    endfunction

    task automatic bus_write(input logic [6:0] dev, input logic [7:0] ra, input int n,
                             output logic ok);
        logic a;
        start_c();
        send_byte({dev, 1'b0}, a);
        ok = a;
        if (a) begin
            send_byte(ra, a); ok = ok & a;
            for (int i = 0; i < n; i++) begin
                send_byte(wbuf[i], a); ok = ok & a;
            end
        end
        stop_c();
    endtask

    task automatic bus_read(input logic [6:0] dev, input logic [7:0] ra, input int n);
        logic a;
        start_c();
        send_byte({dev, 1'b0}, a);
        send_byte(ra, a);
        start_c();
        send_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        stop_c();
    endtask

    task automatic wr1(input logic [7:0] ra, input logic [7:0] v);
        logic ok;
        wbuf[0] = v;
        bus_write(dev_of(addr_sel), ra, 1, ok);
    endtask

    task automatic rd1(input logic [7:0] ra, output logic [7:0] v);
        bus_read(dev_of(addr_sel), ra, 1);
        v = rbuf[0];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before the sequence ended");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       ok, a;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();

        // R11: reset state
        check("R11 sda_oe", sda_oe, 0);
        check("R11 irq_oe", irq_oe, 0);
        check("R11 soft_rst", soft_rst, 0);
        rd1(A_CTRL, v); check("R11 ctrl", v, 8'h00);
        rd1(A_EN, v);   check("R11 enable", v, 8'h00);
        rd1(A_GP + 8'd2, v); check("R11 gp2", v, 8'h00);

        // R2: single write then read
        wr1(A_GP, 8'h5A);
        rd1(A_GP, v); check("R2 gp0", v, 8'h5A);
        wr1(A_EN, 8'h00);
        rd1(A_EN, v); check("R2 enable", v, 8'h00);

        // R1: foreign address is not acknowledged and changes nothing
        wbuf[0] = 8'hFF;
        bus_write(7'h6F, A_GP, 1, ok);
        check("R1 foreign nack", ok, 0);
        check("R13 released after nack", sda_oe, 0);
        rd1(A_GP, v); check("R1 gp0 untouched", v, 8'h5A);
        wbuf[0] = 8'h33;
        bus_write(dev_of(1'b0), A_GP + 8'd1, 1, ok);
        check("R1 own ack", ok, 1);

        // R3: incrementing write
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        bus_write(dev_of(1'b0), A_GP, 4, ok);
        for (int i = 0; i < NGP; i++) begin
            rd1(A_GP + 8'(i), v);
            check("R3 increment", v, 32'(8'h11 * (i + 1)));
            gp_model[i] = 8'(8'h11 * (i + 1));
        end

        // R4: repeated read returns the same register
        bus_read(dev_of(1'b0), A_GP + 8'd1, 3);
        for (int i = 0; i < 3; i++) check("R4 same register", rbuf[i], 8'h22);
        check("R13 released after final nack", sda_oe, 0);

        // R5: memory bursts
        for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i);
        bus_write(dev_of(1'b0), A_MA, 5, ok);
        for (int i = 0; i < 5; i++) wbuf[i] = 8'hB0 + 8'(i);
        bus_write(dev_of(1'b0), A_MB, 5, ok);
        for (int i = 0; i < 5; i++) begin
            ra_a = 4'(i); ra_b = 4'(i); wq();
            check("R5 memory A", rd_a, 32'(8'hA0 + 8'(i)));
            check("R5 memory B", rd_b, 32'(8'hB0 + 8'(i)));
        end
        wbuf[0] = 8'hC0; wbuf[1] = 8'hC1;
        bus_write(dev_of(1'b0), A_MA, 2, ok);
        ra_a = 4'd0; wq(); check("R5 index restart loc0", rd_a, 8'hC0);
        ra_a = 4'd1; wq(); check("R5 index restart loc1", rd_a, 8'hC1);
        ra_a = 4'd2; wq(); check("R5 loc2 kept", rd_a, 8'hA2);
        rd1(A_MA, v); check("R10 port reads zero", v, 8'h00);

        // R6: overflow bytes dropped
        for (int i = 0; i < DEPTH + 2; i++) wbuf[i] = 8'h40 + 8'(i);
        bus_write(dev_of(1'b0), A_MB, DEPTH + 2, ok);
        check("R6 overflow acked", ok, 1);
        ra_b = 4'd0; wq(); check("R6 loc0 not wrapped", rd_b, 8'h40);
        ra_b = 4'd1; wq(); check("R6 loc1 not wrapped", rd_b, 8'h41);
        ra_b = 4'(DEPTH - 1); wq(); check("R6 last loc", rd_b, 32'(8'h40 + 8'(DEPTH - 1)));

        // R10: ignored writes, zero reads
        wr1(A_STS, 8'hFF);
        wr1(A_FLG, 8'hFF);
        check("R10 flag write ignored irq", irq_oe, 0);
        wr1(A_NONE, 8'h77);
        rd1(A_NONE, v); check("R10 unmapped reads zero", v, 8'h00);
        rd1(A_FLG, v); check("R10 flags unchanged", v, 8'h00);

        // R7: masked event, raw status, enable
        evt = 8'h04; repeat (2) @(negedge clk); evt = 8'h00; wq();
        check("R7 masked no irq", irq_oe, 0);
        evt = 8'h80;
        rd1(A_STS, v); check("R7 raw status", v, 8'h80);
        evt = 8'h00;
        wr1(A_EN, 8'h04); wq();
        check("R7 irq enabled", irq_oe, 1);

        // R8: clear on read
        rd1(A_FLG, v); check("R8 flags returned", v, 8'h84);
        check("R8 irq released", irq_oe, 0);
        rd1(A_FLG, v); check("R8 flags cleared", v, 8'h00);

        // R9: soft reset after stop
        srst_cnt = 0;
        start_c(); send_byte({dev_of(1'b0), 1'b0}, a);
        send_byte(A_CTRL, a); send_byte(8'h01, a);
        wq();
        check("R9 no pulse before stop", srst_cnt, 0);
        stop_c();
        repeat (10) @(negedge clk);
        check("R9 one pulse", srst_cnt, 1);
        rd1(A_CTRL, v); check("R9 bit cleared", v, 8'h00);
        check("R9 still one pulse", srst_cnt, 1);

        // R12: strap high
        addr_sel = 1'b1;
        wbuf[0] = 8'h99;
        bus_write(7'h6E, A_GP, 1, ok);
        check("R12 low address refused", ok, 0);
        bus_write(7'h6F, A_GP, 1, ok);
        check("R12 high address taken", ok, 1);
        gp_model[0] = 8'h99;
        rd1(A_GP, v); check("R12 readback", v, 8'h99);

        // R2 R3: random register traffic against a model
        for (int it = 0; it < 20; it++) begin
            int k, n;
            addr_sel = 1'($urandom_range(0, 1));
            k = $urandom_range(0, NGP - 1);
            n = $urandom_range(1, NGP - k);
            for (int j = 0; j < n; j++) begin
                wbuf[j] = 8'($urandom);
                gp_model[k + j] = wbuf[j];
            end
            bus_write(dev_of(addr_sel), A_GP + 8'(k), n, ok);
            check("R3 random write ack", ok, 1);
            k = $urandom_range(0, NGP - 1);
            rd1(A_GP + 8'(k), v);
            check("R2 random readback", v, gp_model[k]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule